// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block carries an 8-bit processor core from its current instruction stream into a service routine. When the surrounding control logic decides to take a maskable interrupt, a non-maskable interrupt or a software break, it pulses one start input. The sequencer then takes over the bus for a fixed run of cycles. It performs dummy reads at the program counter and pushes the return address and a packed status byte onto the stack page. It then reads a 16-bit vector and returns the updated program counter, stack pointer and interrupt-disable flag to the core.

Hardware entries take seven cycles. A break takes six, because the core has already fetched its opcode. The break's dummy read advances the program counter, so the saved return address skips one padding byte. The non-maskable line is edge-captured inside the block and held pending until it is consumed. A pending NMI seen during a break's status push takes over the vector fetch.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `busy`, `we`, `done` and `nmi_pend` are all 0.
- R2: After a hardware start (IRQ or NMI), the first two cycles are reads (`we`=0) with `addr` equal to the captured `pc_in`.
- R3: The next two cycles write the return address high byte, then the low byte. The high byte goes to address 0x0100 | SP and the low byte to 0x0100 | (SP-1), wrapping within the page. `sp_out` drops by one after every write cycle.
- R4: The fifth write-free-to-write cycle, the third write, stores a status byte to 0x0100 | (SP-2). Its bit 7 is N, bit 6 V, bit 5 constant 1, bit 4 break flag, bit 3 D, bit 2 I, bit 1 Z and bit 0 C. `flags_in` supplies {N,V,D,I,Z,C} as bits 5..0. The break flag is 0 for IRQ and NMI and 1 for a break, and the I value pushed is the one held before entry.
- R5: `iflag_out` is 1 from the cycle after the status push. After the sequence `sp_out` equals `sp_in` minus 3 modulo 256.
- R6: The IRQ and break vector is read from 0xFFFE (low byte) and then 0xFFFF (high byte). The NMI vector is read from 0xFFFA and then 0xFFFB. After completion, `pc_out` equals {high byte, low byte}.
- R7: `done` is a one-cycle pulse in the cycle that reads the vector high byte. `busy` is 0 in the following cycle.
- R8: A break start skips the first dummy read. Its first cycle reads at `pc_in`, and the pushed return address is `pc_in`+1, carrying into the high byte.
- R9: `nmi_pend` is set one cycle after a rising edge of `nmi_in` and stays set until an NMI entry is accepted. A line that stays high sets it only once.
- R10: If `nmi_pend` is 1 during a break's status-push cycle, the vector is fetched from 0xFFFA/0xFFFB and `nmi_pend` clears. The pushed break flag remains 1.
- R11: Start inputs are taken only while `busy` is 0, with priority NMI over IRQ over break. Any start raised while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_irq | input | 1 | Begin a maskable interrupt entry |
| start_nmi | input | 1 | Begin a non-maskable interrupt entry |
| start_brk | input | 1 | Begin a software break entry |
| nmi_in | input | 1 | Raw non-maskable request line, edge captured |
| flags_in | input | 6 | Core flags {N,V,D,I,Z,C} |
| pc_in | input | 16 | Program counter at entry |
| sp_in | input | 8 | Stack pointer at entry |
| rdata | input | 8 | Bus read data |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Bus write data |
| we | output | 1 | Bus write enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Vector high byte read this cycle |
| pc_out | output | 16 | New program counter |
| sp_out | output | 8 | New stack pointer |
| iflag_out | output | 1 | Interrupt-disable flag |
| nmi_pend | output | 1 | Latched NMI request |

## Verification
Counted from the first cycle after the accepting edge, a hardware entry shows its dummy reads in cycles 0 and 1 and its three pushes in cycles 2 to 4. The vector reads fall in cycles 5 and 6, with `done` in cycle 6, and `pc_out`, `sp_out` and `iflag_out` settle in cycle 7. A break shifts all of these one cycle earlier. The bench drives starts on a falling edge and releases them on the next one. It then samples each bus cycle on the falling edge inside it, so every check lands on the cycle number given above. NMI latching is checked one cycle after the line rises. The break takeover is checked on the vector-low cycle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DUMMY0,
      ST_DUMMY1,
      ST_PUSH_HI,
      ST_PUSH_LO,
      ST_PUSH_PSW,
      ST_VEC_LO,
      ST_VEC_HI
   } seq_state_t;

   typedef enum logic [1:0] {
      SRC_IRQ,
      SRC_NMI,
      SRC_BRK
   } entry_src_t;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch #(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_in,
   input  logic consume,
   output logic pending
);
   logic lvl;
   logic prev_q;
   logic pend_q;
   logic edge_seen;

   generate
      if (ACTIVE_LOW) begin : g_low
         assign lvl = ~nmi_in;
      end else begin : g_high
         assign lvl = nmi_in;
      end
   endgenerate

   assign edge_seen = lvl & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= lvl;
         if (edge_seen)
            pend_q <= 1'b1;
         else if (consume)
            pend_q <= 1'b0;
      end
   end

   assign pending = pend_q;

   // R9: a pending request survives until it is consumed
   assert_nmi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !consume) |=> pend_q);
   // R9: no edge means no new pending request
   assert_nmi_noedge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !(lvl && !prev_q)) |=> !pend_q);
endmodule

// File: rtl/status_packer.sv
module status_packer #(
   parameter int DATA_W = 8
) (
   input  logic [5:0]        flags,
   input  logic              brk_flag,
   output logic [DATA_W-1:0] packed_byte
);
   localparam int POS_N = 7;
   localparam int POS_V = 6;
   localparam int POS_ONE = 5;
   localparam int POS_B = 4;
   localparam int POS_D = 3;
   localparam int POS_I = 2;
   localparam int POS_Z = 1;
   localparam int POS_C = 0;

   always_comb begin
      packed_byte          = '0;
      packed_byte[POS_N]   = flags[5];
      packed_byte[POS_V]   = flags[4];
      packed_byte[POS_ONE] = 1'b1;
      packed_byte[POS_B]   = brk_flag;
      packed_byte[POS_D]   = flags[3];
      packed_byte[POS_I]   = flags[2];
      packed_byte[POS_Z]   = flags[1];
      packed_byte[POS_C]   = flags[0];
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int                 ADDR_W         = 16,
   parameter int                 DATA_W         = 8,
   parameter logic [DATA_W-1:0]  STACK_PAGE     = 8'h01,
   parameter logic [ADDR_W-1:0]  IRQ_VEC        = 16'hFFFE,
   parameter logic [ADDR_W-1:0]  NMI_VEC        = 16'hFFFA,
   parameter bit                 NMI_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_irq,
   input  logic              start_nmi,
   input  logic              start_brk,
   input  logic              nmi_in,
   input  logic [5:0]        flags_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata,
   output logic              we,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] pc_out,
   output logic [DATA_W-1:0] sp_out,
   output logic              iflag_out,
   output logic              nmi_pend
);
   localparam int FLAG_I = 2;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("irq_entry_seq: DATA_W must be 8");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
         $error("irq_entry_seq: ADDR_W must be twice DATA_W");
      end
      if (IRQ_VEC[0] != 1'b0 || NMI_VEC[0] != 1'b0) begin : g_bad_vec
         $error("irq_entry_seq: vectors must be even");
      end
   endgenerate

   seq_state_t        state_q;
   entry_src_t        src_q;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] sp_q;
   logic [5:0]        flags_q;
   logic              iflag_q;
   logic [ADDR_W-1:0] vec_q;
   logic              consume;
   logic              takeover;
   logic [DATA_W-1:0] psw_byte;

   assign takeover = (state_q == ST_PUSH_PSW) && (src_q == SRC_BRK) && nmi_pend;
   assign consume  = ((state_q == ST_IDLE) && start_nmi) || takeover;

   nmi_edge_latch #(.ACTIVE_LOW(NMI_ACTIVE_LOW)) u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .nmi_in  (nmi_in),
      .consume (consume),
      .pending (nmi_pend)
   );

   status_packer #(.DATA_W(DATA_W)) u_pack (
      .flags       (flags_q),
      .brk_flag    (src_q == SRC_BRK),
      .packed_byte (psw_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         src_q   <= SRC_IRQ;
         pc_q    <= '0;
         sp_q    <= '1;
         flags_q <= '0;
         iflag_q <= 1'b1;
         vec_q   <= IRQ_VEC;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_nmi || start_irq || start_brk) begin
                  pc_q    <= pc_in;
                  sp_q    <= sp_in;
                  flags_q <= flags_in;
                  iflag_q <= flags_in[FLAG_I];
               end
               if (start_nmi) begin
                  src_q   <= SRC_NMI;
                  vec_q   <= NMI_VEC;
                  state_q <= ST_DUMMY0;
               end else if (start_irq) begin
                  src_q   <= SRC_IRQ;
                  vec_q   <= IRQ_VEC;
                  state_q <= ST_DUMMY0;
               end else if (start_brk) begin
                  src_q   <= SRC_BRK;
                  vec_q   <= IRQ_VEC;
                  state_q <= ST_DUMMY1;
               end
            end
            ST_DUMMY0: state_q <= ST_DUMMY1;
            ST_DUMMY1: begin
               if (src_q == SRC_BRK)
                  pc_q <= pc_q + 1'b1;
               state_q <= ST_PUSH_HI;
            end
            ST_PUSH_HI: begin
               sp_q    <= sp_q - 1'b1;
               state_q <= ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
               sp_q    <= sp_q - 1'b1;
               state_q <= ST_PUSH_PSW;
            end
            ST_PUSH_PSW: begin
               sp_q    <= sp_q - 1'b1;
               iflag_q <= 1'b1;
               if (takeover)
                  vec_q <= NMI_VEC;
               state_q <= ST_VEC_LO;
            end
            ST_VEC_LO: begin
               pc_q[DATA_W-1:0] <= rdata;
               state_q          <= ST_VEC_HI;
            end
            ST_VEC_HI: begin
               pc_q[ADDR_W-1:DATA_W] <= rdata;
               state_q               <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      addr  = pc_q;
      wdata = '0;
      we    = 1'b0;
      unique case (state_q)
         ST_PUSH_HI: begin
            addr  = {STACK_PAGE, sp_q};
            wdata = pc_q[ADDR_W-1:DATA_W];
            we    = 1'b1;
         end
         ST_PUSH_LO: begin
            addr  = {STACK_PAGE, sp_q};
            wdata = pc_q[DATA_W-1:0];
            we    = 1'b1;
         end
         ST_PUSH_PSW: begin
            addr  = {STACK_PAGE, sp_q};
            wdata = psw_byte;
            we    = 1'b1;
         end
         ST_VEC_LO: addr = vec_q;
         ST_VEC_HI: addr = vec_q + 1'b1;
         default: addr = pc_q;
      endcase
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_VEC_HI);
   assign pc_out    = pc_q;
   assign sp_out    = sp_q;
   assign iflag_out = iflag_q;

   // R3: every write lands in the stack page
   assert_push_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (addr[ADDR_W-1:DATA_W] == STACK_PAGE));
   // R3: the stack pointer steps down once per write
   assert_sp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (sp_out == DATA_W'($past(sp_out) - 1'b1)));
   // R5: interrupt-disable is set after the status push
   assert_iflag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PUSH_PSW) |=> iflag_out);
   // R6: the high vector byte follows the low one
   assert_vec_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (addr == $past(addr) + 1'b1));
   // R7: done is a single pulse that ends the sequence
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   // R10: pending NMI during a break push redirects the vector fetch
   assert_takeover_R10: assert property (@(posedge clk) disable iff (!rst_n)
      takeover |=> (addr == NMI_VEC && !nmi_pend));
   // R11: a running sequence is not restarted
   assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_irq = 1'b0;
   logic        start_nmi = 1'b0;
   logic        start_brk = 1'b0;
   logic        nmi_in = 1'b0;
   logic [5:0]  flags_in = '0;
   logic [15:0] pc_in = '0;
   logic [7:0]  sp_in = '0;
   logic [7:0]  rdata;
   logic [15:0] addr;
   logic [7:0]  wdata;
   logic        we;
   logic        busy;
   logic        done;
   logic [15:0] pc_out;
   logic [7:0]  sp_out;
   logic        iflag_out;
   logic        nmi_pend;

   int checks = 0;
   int fails = 0;

   localparam logic [7:0] IRQ_LO = 8'h80, IRQ_HI = 8'hE0;
   localparam logic [7:0] NMI_LO = 8'h23, NMI_HI = 8'hF1;

   always #10 clk = ~clk;

   always_comb begin
      case (addr)
         16'hFFFE: rdata = IRQ_LO;
         16'hFFFF: rdata = IRQ_HI;
         16'hFFFA: rdata = NMI_LO;
         16'hFFFB: rdata = NMI_HI;
         default:  rdata = 8'hEA;
      endcase
   end

   irq_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .start_irq(start_irq), .start_nmi(start_nmi),
      .start_brk(start_brk), .nmi_in(nmi_in), .flags_in(flags_in), .pc_in(pc_in),
      .sp_in(sp_in), .rdata(rdata), .addr(addr), .wdata(wdata), .we(we),
      .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out),
      .iflag_out(iflag_out), .nmi_pend(nmi_pend)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // starts: bit0 irq, bit1 nmi, bit2 brk
   task automatic exec_seq(input logic [2:0] starts, input logic [15:0] pc,
                           input logic [7:0] sp, input logic [5:0] fl,
                           input bit takeover, input bit poke);
      bit is_nmi = starts[1];
      bit is_brk = !starts[1] && !starts[0] && starts[2];
      bit nmi_vec = is_nmi || takeover;
      logic [15:0] ret = is_brk ? pc + 16'd1 : pc;
      logic [7:0]  psw = {fl[5], fl[4], 1'b1, is_brk, fl[3:0]};
      logic [15:0] vaddr = nmi_vec ? 16'hFFFA : 16'hFFFE;
      logic [15:0] vexp = nmi_vec ? {NMI_HI, NMI_LO} : {IRQ_HI, IRQ_LO};
      @(negedge clk);
      pc_in = pc; sp_in = sp; flags_in = fl;
      {start_brk, start_nmi, start_irq} = starts;
      @(negedge clk);
      {start_brk, start_nmi, start_irq} = 3'b000;
      if (!is_brk) begin
         chk("R2", "dummy0 addr", 32'(addr), 32'(pc));
         chk("R2", "dummy0 we", 32'(we), 0);
         @(negedge clk);
      end
      chk("R8", "dummy1 addr", 32'(addr), 32'(pc));
      chk("R2", "dummy1 we", 32'(we), 0);
      chk("R11", "busy", 32'(busy), 1);
      if (takeover) nmi_in = 1'b1;
      @(negedge clk);
      chk("R3", "push hi addr", 32'(addr), 32'({8'h01, sp}));
      chk("R3", "push hi data", 32'(wdata), 32'(ret[15:8]));
      chk("R3", "push hi we", 32'(we), 1);
      if (poke) start_nmi = 1'b1;
      @(negedge clk);
      start_nmi = 1'b0;
      chk("R3", "push lo addr", 32'(addr), 32'({8'h01, 8'(sp - 8'd1)}));
      chk("R3", "push lo data", 32'(wdata), 32'(ret[7:0]));
      chk("R3", "sp after one push", 32'(sp_out), 32'(8'(sp - 8'd1)));
      @(negedge clk);
      chk("R4", "psw addr", 32'(addr), 32'({8'h01, 8'(sp - 8'd2)}));
      chk("R4", "psw data", 32'(wdata), 32'(psw));
      chk("R4", "psw we", 32'(we), 1);
      @(negedge clk);
      chk("R6", "vec lo addr", 32'(addr), 32'(vaddr));
      chk("R6", "vec lo we", 32'(we), 0);
      chk("R5", "iflag", 32'(iflag_out), 1);
      if (takeover) chk("R10", "pending cleared", 32'(nmi_pend), 0);
      @(negedge clk);
      chk("R6", "vec hi addr", 32'(addr), 32'(vaddr + 16'd1));
      chk("R7", "done", 32'(done), 1);
      @(negedge clk);
      chk("R7", "done low", 32'(done), 0);
      chk("R7", "busy low", 32'(busy), 0);
      chk("R6", "pc_out", 32'(pc_out), 32'(vexp));
      chk("R5", "sp_out", 32'(sp_out), 32'(8'(sp - 8'd3)));
      chk("R5", "iflag after", 32'(iflag_out), 1);
      if (takeover) nmi_in = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "busy", 32'(busy), 0);
      chk("R1", "we", 32'(we), 0);
      chk("R1", "done", 32'(done), 0);
      chk("R1", "nmi_pend", 32'(nmi_pend), 0);
   endtask

   task automatic t_irq;
      exec_seq(3'b001, 16'h1234, 8'hFF, 6'b110011, 1'b0, 1'b0);
      exec_seq(3'b001, 16'hA5C3, 8'h01, 6'b001100, 1'b0, 1'b0); // stack wrap
   endtask

   task automatic t_nmi;
      @(negedge clk);
      nmi_in = 1'b1;
      @(negedge clk);
      chk("R9", "pending after edge", 32'(nmi_pend), 1);
      @(negedge clk);
      chk("R9", "pending held", 32'(nmi_pend), 1);
      exec_seq(3'b010, 16'h4000, 8'h80, 6'b000001, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      chk("R9", "level high sets once", 32'(nmi_pend), 0);
      nmi_in = 1'b0;
   endtask

   task automatic t_brk;
      exec_seq(3'b100, 16'hC0FF, 8'h40, 6'b100101, 1'b0, 1'b1);
   endtask

   task automatic t_takeover;
      exec_seq(3'b100, 16'h0200, 8'hF0, 6'b011010, 1'b1, 1'b0);
   endtask

   task automatic t_priority;
      exec_seq(3'b011, 16'h7777, 8'h20, 6'b000000, 1'b0, 1'b0);
      exec_seq(3'b101, 16'h1111, 8'h30, 6'b000000, 1'b0, 1'b0);
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_irq();
      t_nmi();
      t_brk();
      t_takeover();
      t_priority();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule